// File: doc/BRIEF.md
# Paired Address/Data Memory Port

This block sits between a processor's result bus and one single-port data memory of 16-bit words. It holds three address registers and three data registers, bound in fixed pairs. Writing a result into an address register sets the memory address and, on the same clock edge, loads the word stored there into the partner data register. Writing a result into a data register stores that value in the register and in memory, at the address held by the partner address register. Operand logic sees all six registers at once, so the single memory behaves like a small multi-ported store.

A write-enable qualifies every update, and a three-bit destination code selects the register. The memory address is a four-way selection: the result bus, or one of the three address registers. Inside the block, the shared write/read data path has two drivers: the result bus and the memory output. Their enables are never both active. The memory address leaves the block with an output enable. A takeover input drops that enable so an outside agent can own the address bus, and it also blocks memory writes.

The address space is 64K words. For standalone use, the block contains a memory array indexed by the low `MEM_AW` address bits. Higher address bits alias onto those low bits.

Top module: `pair_mem_port`

## Requirements
- R1: While reset is held, and directly after it, all six registers read zero. `memWe` is low, `memAddr` is 0 and `memAddrOe` is high.
- R2: `dstSel[2]` selects the register kind: 0 for address, 1 for data. `dstSel[1:0]` gives the pair number, 1 to 3. Pair number 0 (codes 0 and 4) is ignored even when `wrEn` is high: no register changes and `memWe` stays low.
- R3: An address write to pair n takes effect on the clock edge. An gets `resBus`, and Dn gets the memory word at `resBus`, both on that same edge.
- R4: A data write to pair n takes effect on the clock edge. Dn gets `resBus`, memory at An stores `resBus`, and An is unchanged. The result driver and the memory-output driver are never enabled together.
- R5: `memWe` is high in exactly those cycles that hold a valid data write with `takeover` low, and low in all other cycles.
- R6: During an address write, `memAddr` equals `resBus`. During a data write it equals the partner address register. In all other cycles it equals A1.
- R7: While `takeover` is high, `memAddrOe` is low and memory is not written. The register updates of R3 and R4 still happen.
- R8: A data write followed in the next cycle by an address write of the same address returns the new value. This holds through the same pair or through any other pair.
- R9: Registers change only on the rising clock edge. A Dn value fed back as the next address (pointer chasing) therefore walks a stored chain one link per cycle.
- R10: With `wrEn` low, no register changes and `memWe` stays low, whatever `dstSel` and `resBus` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of the registers |
| resBus | input | 16 | Result bus value to store |
| dstSel | input | 3 | Destination code: bit 2 selects address or data, bits 1:0 give the pair |
| wrEn | input | 1 | Write strobe qualifying `dstSel` |
| takeover | input | 1 | External bus takeover: releases the address and blocks writes |
| aRegs | output | 48 | A1..A3 packed, A1 in bits 15:0 |
| dRegs | output | 48 | D1..D3 packed, D1 in bits 15:0 |
| memAddr | output | 16 | Memory address selected this cycle |
| memAddrOe | output | 1 | Address output enable, low during takeover |
| memWe | output | 1 | Memory write strobe |

## Verification
The bench targets four corner cases.

- **Same-address readback.** It reads an address back in the cycle right after writing it, through the same pair and through other pairs. A design with a registered memory read, or with the write ordered after the read, would return the stale word.
- **Pointer chasing.** It walks a pointer chain by feeding D1 back as the next A1 value. A data register that was transparent, or that loaded a cycle late, would skip or repeat links.
- **Takeover during a data write.** It issues data writes under takeover and then reads the same location. A design that ignored takeover would overwrite memory and keep the address enabled.
- **Ignored codes and idle cycles.** It drives the ignored pair codes and idle write-enable cycles. A loose decoder would then corrupt a register or raise the write strobe.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int PAIRS = 3;
  localparam int SEL_W = $clog2(PAIRS + 1);
  localparam int DST_W = SEL_W + 1;

  // Strobes from control to datapath. addrSel 0 = result bus, k = pair k.
  typedef struct packed {
    logic [PAIRS-1:0] aLoad;
    logic [PAIRS-1:0] dLoad;
    logic [SEL_W-1:0] addrSel;
    logic             resDrv;
    logic             memDrv;
    logic             memWe;
  } pmpStrobes_t;
endpackage

// File: rtl/pmp_ctrl.sv
module pmp_ctrl
  import pmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              takeover,
  input  logic [DST_W-1:0]  dstSel,
  output pmpStrobes_t       strobes
);
  logic [SEL_W-1:0] pairIdx;
  logic             isData;
  logic             validWr;
  logic [PAIRS-1:0] aLoadV;
  logic [PAIRS-1:0] dLoadV;

  assign pairIdx = dstSel[SEL_W-1:0];
  assign isData  = dstSel[DST_W-1];
  assign validWr = wrEn && (pairIdx != '0) && (int'(pairIdx) <= PAIRS);

  for (genvar i = 0; i < PAIRS; i++) begin : g_decode
    assign aLoadV[i] = validWr && !isData && (pairIdx == SEL_W'(i + 1));
    assign dLoadV[i] = validWr &&  isData && (pairIdx == SEL_W'(i + 1));
  end

  always_comb begin
    strobes.aLoad   = aLoadV;
    strobes.dLoad   = dLoadV;
    if (!validWr)    strobes.addrSel = SEL_W'(1);
    else if (isData) strobes.addrSel = pairIdx;
    else             strobes.addrSel = '0;
    strobes.resDrv  = validWr && isData;
    strobes.memDrv  = ~|dLoadV;
    strobes.memWe   = (|dLoadV) && !takeover;
  end

  AST_LOADS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aLoadV, dLoadV})); // R2
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ({aLoadV, dLoadV} == '0)); // R10
endmodule

// File: rtl/pmp_datapath.sv
module pmp_datapath
  import pmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WIDTH-1:0]       resBus,
  input  pmpStrobes_t            strobes,
  input  logic [WIDTH-1:0]       memRdata,
  output logic [PAIRS*WIDTH-1:0] aRegs,
  output logic [PAIRS*WIDTH-1:0] dRegs,
  output logic [WIDTH-1:0]       memAddr,
  output logic [WIDTH-1:0]       memWdata
);
  logic [WIDTH-1:0] aReg [PAIRS];
  logic [WIDTH-1:0] dReg [PAIRS];
  logic [WIDTH-1:0] addrCand [PAIRS+1];
  logic [WIDTH-1:0] dataBus;

  // Two gated drivers onto one shared data path; control keeps them exclusive.
  assign dataBus  = (strobes.resDrv ? resBus : '0) | (strobes.memDrv ? memRdata : '0);
  assign memWdata = dataBus;

  assign addrCand[0] = resBus;
  assign memAddr     = addrCand[strobes.addrSel];

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign addrCand[i+1]           = aReg[i];
    assign aRegs[i*WIDTH +: WIDTH] = aReg[i];
    assign dRegs[i*WIDTH +: WIDTH] = dReg[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aReg[i] <= '0;
        dReg[i] <= '0;
      end else begin
        if (strobes.aLoad[i]) aReg[i] <= resBus;
        if (strobes.aLoad[i] || strobes.dLoad[i]) dReg[i] <= dataBus;
      end
    end

    AST_A_TAKES_RESULT: assert property (@(posedge clk) disable iff (!rstN)
      strobes.aLoad[i] |=> (aReg[i] == $past(resBus))); // R3
    AST_D_TAKES_RESULT: assert property (@(posedge clk) disable iff (!rstN)
      strobes.dLoad[i] |=> (dReg[i] == $past(resBus))); // R4
    AST_A_HELD_ON_D: assert property (@(posedge clk) disable iff (!rstN)
      strobes.dLoad[i] |=> $stable(aReg[i])); // R4
    AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
      strobes.dLoad[i] |-> (memAddr == aReg[i])); // R6
  end

  AST_ENABLES_COMPL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resDrv != strobes.memDrv); // R4
endmodule

// File: rtl/pmp_mem.sv
module pmp_mem #(
  parameter int WIDTH  = 16,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/pair_mem_port.sv
module pair_mem_port
  import pmp_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int MEM_AW = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WIDTH-1:0]       resBus,
  input  logic [DST_W-1:0]       dstSel,
  input  logic                   wrEn,
  input  logic                   takeover,
  output logic [PAIRS*WIDTH-1:0] aRegs,
  output logic [PAIRS*WIDTH-1:0] dRegs,
  output logic [WIDTH-1:0]       memAddr,
  output logic                   memAddrOe,
  output logic                   memWe
);
  pmpStrobes_t      strobes;
  logic [WIDTH-1:0] memRdata;
  logic [WIDTH-1:0] memWdata;

  pmp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .takeover (takeover),
    .dstSel   (dstSel),
    .strobes  (strobes)
  );

  pmp_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .resBus   (resBus),
    .strobes  (strobes),
    .memRdata (memRdata),
    .aRegs    (aRegs),
    .dRegs    (dRegs),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  pmp_mem #(.WIDTH(WIDTH), .MEM_AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (strobes.memWe),
    .addr  (memAddr[MEM_AW-1:0]),
    .wdata (memWdata),
    .rdata (memRdata)
  );

  assign memWe     = strobes.memWe;
  assign memAddrOe = !takeover;

  AST_WE_NEEDS_DLOAD: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(strobes.dLoad) == 1)); // R5
  AST_TAKEOVER_BLOCKS_WE: assert property (@(posedge clk) disable iff (!rstN)
    takeover |-> !memWe); // R7
endmodule

// File: tb/pair_mem_port_tb_top.sv
`timescale 1ns/1ps
module pair_mem_port_tb_top;
  localparam int W = 16;
  localparam int MAW = 8;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] resBus = '0;
  logic [2:0] dstSel = '0;
  logic wrEn = 1'b0;
  logic takeover = 1'b0;
  logic [NP*W-1:0] aRegs, dRegs;
  logic [W-1:0] memAddr;
  logic memAddrOe, memWe;

  int checkCnt = 0;
  int failCnt = 0;

  logic [W-1:0] expA [NP];
  logic [W-1:0] expD [NP];
  bit           expDKnown [NP];
  logic [W-1:0] memModel [1 << MAW];
  bit           memKnown [1 << MAW];

  always #5 clk = ~clk;

  pair_mem_port dut_i (
    .clk(clk), .rstN(rstN), .resBus(resBus), .dstSel(dstSel), .wrEn(wrEn),
    .takeover(takeover), .aRegs(aRegs), .dRegs(dRegs), .memAddr(memAddr),
    .memAddrOe(memAddrOe), .memWe(memWe)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chkRegs(string tag);
    for (int i = 0; i < NP; i++) begin
      chk(tag, $sformatf("A%0d", i + 1), 64'(aRegs[i*W +: W]), 64'(expA[i]));
      if (expDKnown[i])
        chk(tag, $sformatf("D%0d", i + 1), 64'(dRegs[i*W +: W]), 64'(expD[i]));
    end
  endtask

  function automatic string tagOf(bit we, logic [2:0] sel, bit tko);
    if (!we) return "R10";
    if (sel[1:0] == 2'd0) return "R2";
    if (tko) return "R7";
    return sel[2] ? "R4" : "R3";
  endfunction

  // One bus cycle: drive at negedge, check the combinational outputs, then the registers after the edge.
  task automatic step(bit we, logic [2:0] sel, logic [W-1:0] res, bit tko, string tag);
    int idx;
    bit valid, isData, expWe;
    logic [W-1:0] expAddr;
    @(negedge clk);
    wrEn = we; dstSel = sel; resBus = res; takeover = tko;
    #1;
    idx = int'(sel[1:0]);
    valid = we && (idx != 0);
    isData = sel[2];
    expWe = valid && isData && !tko;
    expAddr = !valid ? expA[0] : (isData ? expA[idx-1] : res);
    chk("R5", "memWe", 64'(memWe), 64'(expWe));
    chk("R6", "memAddr", 64'(memAddr), 64'(expAddr));
    chk("R7", "memAddrOe", 64'(memAddrOe), 64'(!tko));
    if (valid) begin
      if (!isData) begin
        expA[idx-1] = res;
        expD[idx-1] = memModel[res[MAW-1:0]];
        expDKnown[idx-1] = memKnown[res[MAW-1:0]];
      end else begin
        expD[idx-1] = res;
        expDKnown[idx-1] = 1'b1;
        if (!tko) begin
          memModel[expA[idx-1][MAW-1:0]] = res;
          memKnown[expA[idx-1][MAW-1:0]] = 1'b1;
        end
      end
    end
    @(posedge clk);
    #1;
    chkRegs(tag);
  endtask

  initial begin
    #2000000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    logic [W-1:0] chain [5];
    void'($urandom(32'd1234));
    for (int i = 0; i < NP; i++) begin
      expA[i] = '0; expD[i] = '0; expDKnown[i] = 1'b1;
    end
    for (int i = 0; i < (1 << MAW); i++) memKnown[i] = 1'b0;

    // R1: reset state, during and after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "memWe", 64'(memWe), 64'(0));
    chk("R1", "memAddr", 64'(memAddr), 64'(0));
    chk("R1", "memAddrOe", 64'(memAddrOe), 64'(1));
    chkRegs("R1");
    rstN = 1'b1;
    @(negedge clk);
    chkRegs("R1");

    // Fill memory through pair 1 so every location is known
    for (int a = 0; a < (1 << MAW); a++) begin
      step(1'b1, 3'd1, W'(a), 1'b0, "R3");
      step(1'b1, 3'd5, W'(16'hA500 ^ (a * 37)), 1'b0, "R4");
    end

    // R2: ignored pair codes with wrEn high
    step(1'b1, 3'd0, 16'h1234, 1'b0, "R2");
    step(1'b1, 3'd4, 16'hBEEF, 1'b0, "R2");
    // R10: wrEn low with data and address codes
    step(1'b0, 3'd6, 16'h5555, 1'b0, "R10");
    step(1'b0, 3'd2, 16'h0042, 1'b0, "R10");

    // R8: write then read the same address, same pair and another pair
    step(1'b1, 3'd3, 16'h0077, 1'b0, "R3");
    step(1'b1, 3'd7, 16'hC0DE, 1'b0, "R4");
    step(1'b1, 3'd3, 16'h0077, 1'b0, "R8");
    step(1'b1, 3'd7, 16'hF00D, 1'b0, "R4");
    step(1'b1, 3'd1, 16'h0177, 1'b0, "R8"); // aliases onto location 0x77
    chk("R8", "D1 sees new word", 64'(dRegs[0 +: W]), 64'(16'hF00D));

    // R7: data write under takeover leaves memory untouched, register still loads
    step(1'b1, 3'd2, 16'h0010, 1'b0, "R3");
    step(1'b1, 3'd6, 16'hDEAD, 1'b1, "R7");
    step(1'b1, 3'd2, 16'h0010, 1'b1, "R7");
    chk("R7", "D2 old word", 64'(dRegs[W +: W]), 64'(16'hA500 ^ (16 * 37)));

    // R9: pointer chase, D1 fed back as the next A1
    chain[0] = 16'h0020; chain[1] = 16'h0031; chain[2] = 16'h0005;
    chain[3] = 16'h00E2; chain[4] = 16'h0099;
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 3'd1, chain[k], 1'b0, "R9");
      step(1'b1, 3'd5, chain[k+1], 1'b0, "R9");
    end
    step(1'b1, 3'd1, chain[0], 1'b0, "R9");
    for (int k = 1; k < 5; k++) begin
      chk("R9", "chain link", 64'(dRegs[0 +: W]), 64'(chain[k]));
      step(1'b1, 3'd1, dRegs[0 +: W], 1'b0, "R9");
    end

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bit we, tko;
      logic [2:0] sel;
      logic [W-1:0] res;
      we = ($urandom % 10) != 0;
      tko = ($urandom % 10) == 0;
      sel = 3'($urandom);
      res = W'($urandom);
      step(we, sel, res, tko, tagOf(we, sel, tko));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule